// File: doc/BRIEF.md
# Serial Frame Transmitter with Bus Collision Detection

This block sends 8-bit asynchronous frames on a single line, for point-to-point links and for shared single-wire buses where several stations may drive at once. A one-entry holding buffer sits in front of the frame shifter, so software can queue the next byte while the current one is on the wire. A transmit interrupt is raised either when the buffer hands its byte to the shifter or when a whole frame, stop bit included, has left. The choice is made by a configuration bit.

While a frame is on the wire, the block reads the line level back on its receive input and compares it with the level it drives. The comparison is sampled either in the middle of each bit or on an external timer underflow strobe. A mismatch sets a sticky collision flag. The mismatch can also clear the transmit enable by itself, which ends the frame at the next bit boundary and discards the queued byte. A start-synchronization option holds a queued byte until the receive line shows a falling edge. The option then clears itself.

Top module: `uart_cd_tx`

## Requirements
- R1: The idle line is high. A frame is one low start bit, then 8 data bits with the least significant bit first, then one high stop bit. Each bit lasts `bit_div` clock cycles, and values below 2 are treated as 2.
- R2: The holding buffer has one entry. A write (`tx_we`) is accepted only while `buf_empty` is 1. A write while the buffer is full is ignored and never produces a frame.
- R3: `buf_empty` becomes 1 in the same cycle in which the start bit first appears on `txd`.
- R4: With `cfg_irq_sel` = 0, `tx_irq` pulses for one cycle, in the first cycle of the start bit of each frame.
- R5: With `cfg_irq_sel` = 1, `tx_irq` pulses for one cycle once the stop bit has completed, with `txd` back at idle high.
- R6: While a frame is being sent, a sample where `rxd` differs from `txd` sets `coll_flag`. The flag stays set until it is cleared. Matching samples leave it at 0.
- R7: With `cfg_smp_sel` = 0, the line is sampled at the middle of each bit. With `cfg_smp_sel` = 1, it is sampled only on `tmr_uf` pulses. Without such pulses, no collision is seen.
- R8: A one-cycle pulse on `coll_clr` clears `coll_flag`. A collision in the same cycle wins.
- R9: With `cfg_aclr` = 1, a collision clears `txen`. The frame then stops at the next bit boundary: `txd` returns high and the buffered byte is discarded, even after `txen` is set again.
- R10: With `sync_pend` = 1, a queued byte waits until a falling edge of `rxd`. Its start bit begins in the cycle after the low level is first seen, and `sync_pend` is 0 from that cycle on.
- R11: While `txen` is 0, a written byte stays in the buffer and `txd` stays high. The byte is sent once `txen` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for all configuration bits |
| cfg_ten | input | 1 | Transmit enable value to write |
| cfg_irq_sel | input | 1 | Interrupt cause: 0 buffer handoff, 1 frame complete |
| cfg_smp_sel | input | 1 | Collision strobe: 0 mid-bit, 1 timer underflow |
| cfg_aclr | input | 1 | Clear transmit enable on collision |
| cfg_sync | input | 1 | Wait for an rxd falling edge before starting |
| bit_div | input | DIV_W | Clock cycles per bit |
| tx_we | input | 1 | Write strobe for the holding buffer |
| tx_data | input | DATA_W | Byte to queue |
| coll_clr | input | 1 | Clear the collision flag |
| tmr_uf | input | 1 | External timer underflow strobe |
| rxd | input | 1 | Line level read back |
| txd | output | 1 | Serial output |
| tx_irq | output | 1 | Transmit interrupt pulse |
| buf_empty | output | 1 | Holding buffer is free |
| coll_flag | output | 1 | Sticky collision flag |
| txen | output | 1 | Current transmit enable |
| sync_pend | output | 1 | Start synchronization still armed |

## Verification
Frames of 0xA5, 0x00, 0xFF and 0x3C are sent back to back over a clean loopback. These patterns show up bit-order, stuck-level and stop-bit errors, and a clean loopback must leave the collision flag at 0. The same traffic is repeated under each interrupt cause, and the line level seen at each pulse shows which cause is in force. An inverted loopback, with and without timer strobes, shows which sampling source is active. With automatic clearing on, the inverted loopback must cut the frame to the 4-cycle start bit and discard the queued byte. A line held high and then pulled low shows that start synchronization both waits and releases.

// File: rtl/uart_cd_pkg.sv
package uart_cd_pkg;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } tx_state_e;

   typedef struct packed {
      logic ten;
      logic irq_sel;
      logic smp_sel;
      logic aclr;
      logic sync;
   } tx_cfg_t;

endpackage

// File: rtl/uart_cd_baud.sv
module uart_cd_baud #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] bit_div,
   output logic             bit_end,
   output logic             mid_pulse
);
   localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] eff;

   // divisors below two would give no distinct mid-bit point
   assign eff       = (bit_div < MIN_DIV) ? MIN_DIV : bit_div;
   assign bit_end   = run && (cnt == eff - DIV_W'(1));
   assign mid_pulse = run && (cnt == (eff >> 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt <= '0;
      else if (!run || bit_end)  cnt <= '0;
      else                       cnt <= cnt + DIV_W'(1);
   end
endmodule

// File: rtl/uart_cd_shift.sv
module uart_cd_shift
   import uart_cd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              bit_end,
   input  logic              abort,
   output logic              busy,
   output logic              txd,
   output logic              frame_end
);
   localparam int FRAME_W = DATA_W + 2;
   localparam int IDX_W   = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

   tx_state_e          st;
   logic [FRAME_W-1:0] sh;
   logic [IDX_W-1:0]   idx;

   assign busy      = (st == ST_SHIFT);
   assign txd       = busy ? sh[0] : 1'b1;
   assign frame_end = busy && bit_end && !abort && (idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         sh  <= '1;
         idx <= '0;
      end else if (start) begin
         st  <= ST_SHIFT;
         sh  <= {1'b1, ld_data, 1'b0};
         idx <= '0;
      end else if (busy && bit_end) begin
         if (abort || idx == LAST_IDX) begin
            st  <= ST_IDLE;
            sh  <= '1;
            idx <= '0;
         end else begin
            sh  <= {1'b1, sh[FRAME_W-1:1]};
            idx <= idx + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/uart_cd_coll.sv
module uart_cd_coll #(
   parameter int RXD_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rxd_in,
   input  logic txd,
   input  logic busy,
   input  logic smp_sel,
   input  logic mid_pulse,
   input  logic tmr_uf,
   input  logic clr,
   output logic coll_event,
   output logic coll_flag,
   output logic rxd_fall
);
   logic rxd_s;
   logic txd_ref;
   logic rxd_prev;
   logic strobe;

   generate
      if (RXD_STAGES == 0) begin : g_direct
         assign rxd_s   = rxd_in;
         assign txd_ref = txd;
      end else begin : g_staged
         // the driven level is delayed as far as the read-back level
         logic [RXD_STAGES-1:0] rx_pipe;
         logic [RXD_STAGES-1:0] tx_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_pipe <= '1;
               tx_pipe <= '1;
            end else begin
               rx_pipe <= {rx_pipe[RXD_STAGES-1:0], rxd_in} >> 0;
               tx_pipe <= {tx_pipe[RXD_STAGES-1:0], txd} >> 0;
            end
         end
         assign rxd_s   = rx_pipe[RXD_STAGES-1];
         assign txd_ref = tx_pipe[RXD_STAGES-1];
      end
   endgenerate

   assign strobe     = smp_sel ? tmr_uf : mid_pulse;
   assign coll_event = busy && strobe && (rxd_s != txd_ref);
   assign rxd_fall   = rxd_prev && !rxd_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxd_prev  <= 1'b1;
         coll_flag <= 1'b0;
      end else begin
         rxd_prev <= rxd_s;
         if (coll_event)  coll_flag <= 1'b1;
         else if (clr)    coll_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_cd_tx.sv
module uart_cd_tx
   import uart_cd_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int DIV_W      = 12,
   parameter int RXD_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_ten,
   input  logic              cfg_irq_sel,
   input  logic              cfg_smp_sel,
   input  logic              cfg_aclr,
   input  logic              cfg_sync,
   input  logic [DIV_W-1:0]  bit_div,
   input  logic              tx_we,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              coll_clr,
   input  logic              tmr_uf,
   input  logic              rxd,
   output logic              txd,
   output logic              tx_irq,
   output logic              buf_empty,
   output logic              coll_flag,
   output logic              txen,
   output logic              sync_pend
);
   generate
      if (DATA_W < 1)     begin : g_bad_data  $error("DATA_W must be at least 1"); end
      if (DIV_W < 2)      begin : g_bad_div   $error("DIV_W must be at least 2"); end
      if (RXD_STAGES < 0) begin : g_bad_stage $error("RXD_STAGES must not be negative"); end
   endgenerate

   tx_cfg_t           cfg_q;
   logic              buf_vld;
   logic [DATA_W-1:0] buf_data;
   logic              busy;
   logic              bit_end;
   logic              mid_pulse;
   logic              frame_end;
   logic              coll_event;
   logic              rxd_fall;
   logic              start;
   logic              abort;
   logic              irq_sel_q;
   logic              aclr_q;

   assign irq_sel_q = cfg_q.irq_sel;
   assign aclr_q    = cfg_q.aclr;
   assign abort     = !cfg_q.ten;
   assign start     = !busy && buf_vld && cfg_q.ten && (!cfg_q.sync || rxd_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else begin
         if (coll_event && cfg_q.aclr) cfg_q.ten <= 1'b0;
         else if (cfg_we)              cfg_q.ten <= cfg_ten;
         if (start)                    cfg_q.sync <= 1'b0;
         else if (cfg_we)              cfg_q.sync <= cfg_sync;
         if (cfg_we) begin
            cfg_q.irq_sel <= cfg_irq_sel;
            cfg_q.smp_sel <= cfg_smp_sel;
            cfg_q.aclr    <= cfg_aclr;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_vld  <= 1'b0;
         buf_data <= '0;
      end else if (busy && bit_end && abort) begin
         buf_vld <= 1'b0;
      end else if (start) begin
         buf_vld <= 1'b0;
      end else if (tx_we && !buf_vld) begin
         buf_vld  <= 1'b1;
         buf_data <= tx_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tx_irq <= 1'b0;
      else        tx_irq <= cfg_q.irq_sel ? frame_end : start;
   end

   uart_cd_baud #(.DIV_W(DIV_W)) u_baud (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .bit_div   (bit_div),
      .bit_end   (bit_end),
      .mid_pulse (mid_pulse)
   );

   uart_cd_shift #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ld_data   (buf_data),
      .bit_end   (bit_end),
      .abort     (abort),
      .busy      (busy),
      .txd       (txd),
      .frame_end (frame_end)
   );

   uart_cd_coll #(.RXD_STAGES(RXD_STAGES)) u_coll (
      .clk        (clk),
      .rst_n      (rst_n),
      .rxd_in     (rxd),
      .txd        (txd),
      .busy       (busy),
      .smp_sel    (cfg_q.smp_sel),
      .mid_pulse  (mid_pulse),
      .tmr_uf     (tmr_uf),
      .clr        (coll_clr),
      .coll_event (coll_event),
      .coll_flag  (coll_flag),
      .rxd_fall   (rxd_fall)
   );

   assign buf_empty = !buf_vld;
   assign txen      = cfg_q.ten;
   assign sync_pend = cfg_q.sync;
endmodule

// File: rtl/uart_cd_chk.sv
module uart_cd_chk (
   input logic clk,
   input logic rst_n,
   input logic txd,
   input logic tx_irq,
   input logic buf_empty,
   input logic coll_flag,
   input logic txen,
   input logic sync_pend,
   input logic coll_clr,
   input logic busy,
   input logic coll_event,
   input logic irq_sel,
   input logic aclr
);
   AST_START_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (buf_empty && !txd)); // R3

   AST_IRQ_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq && !$past(irq_sel)) |-> $rose(busy)); // R4

   AST_IRQ_FRAME_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq && $past(irq_sel)) |-> ($fell(busy) && txd)); // R5

   AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      coll_event |=> coll_flag); // R6

   AST_COLL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_clr && !coll_event) |=> !coll_flag); // R8

   AST_AUTO_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_event && aclr) |=> !txen); // R9

   AST_SYNC_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !sync_pend); // R10
endmodule

bind uart_cd_tx uart_cd_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .txd        (txd),
   .tx_irq     (tx_irq),
   .buf_empty  (buf_empty),
   .coll_flag  (coll_flag),
   .txen       (txen),
   .sync_pend  (sync_pend),
   .coll_clr   (coll_clr),
   .busy       (busy),
   .coll_event (coll_event),
   .irq_sel    (irq_sel_q),
   .aclr       (aclr_q)
);

// File: tb/tb_uart_cd_tx.sv
module tb_uart_cd_tx;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 8;
   localparam int DIV_W      = 12;
   localparam int BD         = 4;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic rst_n = 1'b0;
   logic cfg_we = 0, cfg_ten = 0, cfg_irq_sel = 0, cfg_smp_sel = 0, cfg_aclr = 0, cfg_sync = 0;
   logic [DIV_W-1:0] bit_div = DIV_W'(BD);
   logic tx_we = 0;
   logic [DATA_W-1:0] tx_data = '0;
   logic coll_clr = 0, tmr_uf = 0;
   logic rxd;
   logic txd, tx_irq, buf_empty, coll_flag, txen, sync_pend;

   logic loop_en = 1'b1, loop_inv = 1'b0, rxd_drv = 1'b1;
   assign rxd = loop_en ? (txd ^ loop_inv) : rxd_drv;

   uart_cd_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W), .RXD_STAGES(0)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ten(cfg_ten),
      .cfg_irq_sel(cfg_irq_sel), .cfg_smp_sel(cfg_smp_sel), .cfg_aclr(cfg_aclr),
      .cfg_sync(cfg_sync), .bit_div(bit_div), .tx_we(tx_we), .tx_data(tx_data),
      .coll_clr(coll_clr), .tmr_uf(tmr_uf), .rxd(rxd), .txd(txd), .tx_irq(tx_irq),
      .buf_empty(buf_empty), .coll_flag(coll_flag), .txen(txen), .sync_pend(sync_pend)
   );

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   bit mon_en = 1'b1;
   bit exp_sel = 1'b0;
   logic [7:0] sb_q[$];

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // monitor: decodes frames from txd and compares against the scoreboard
   bit         m_act = 1'b0;
   int         m_cyc = 0;
   int         m_bit = 0;
   logic [7:0] m_byte = '0;
   logic [7:0] m_exp = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (tx_irq) begin
            irq_cnt++;
            if (!exp_sel) begin
               chk(txd == 1'b0, "R4", "txd at handoff irq", txd, 0);
               chk(buf_empty == 1'b1, "R3", "buf_empty at start bit", buf_empty, 1);
            end else begin
               chk(txd == 1'b1, "R5", "txd at frame-done irq", txd, 1);
            end
         end
         if (mon_en) begin
            if (!m_act) begin
               if (!txd) begin m_act = 1'b1; m_cyc = 0; end
            end else begin
               m_cyc++;
            end
            if (m_act && (m_cyc % BD) == BD/2) begin
               m_bit = m_cyc / BD;
               if (m_bit == 0) chk(txd == 1'b0, "R1", "start bit level", txd, 0);
               else if (m_bit <= 8) m_byte[m_bit-1] = txd;
               else begin
                  chk(txd == 1'b1, "R1", "stop bit level", txd, 1);
                  if (sb_q.size() == 0) chk(1'b0, "R2", "unexpected frame", m_byte, 0);
                  else begin
                     m_exp = sb_q.pop_front();
                     chk(m_byte == m_exp, "R1", "frame data", m_byte, m_exp);
                  end
                  m_act = 1'b0;
               end
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_cfg(input bit ten, input bit sel, input bit smp, input bit acl, input bit syn);
      @(negedge clk);
      cfg_we = 1; cfg_ten = ten; cfg_irq_sel = sel; cfg_smp_sel = smp; cfg_aclr = acl; cfg_sync = syn;
      exp_sel = sel;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      while (!buf_empty) @(negedge clk);
      tx_we = 1; tx_data = b; sb_q.push_back(b);
      @(negedge clk);
      tx_we = 0;
   endtask

   task automatic raw_write(input logic [7:0] b);
      @(negedge clk);
      tx_we = 1; tx_data = b;
      @(negedge clk);
      tx_we = 0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (sb_q.size() != 0) @(negedge clk);
      tick(4);
   endtask

   task automatic pulse_clr();
      @(negedge clk); coll_clr = 1;
      @(negedge clk); coll_clr = 0;
   endtask

   task automatic count_low(input int n, output int lows);
      lows = 0;
      repeat (n) begin
         @(negedge clk);
         if (!txd) lows++;
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      int base;
      int lows;
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk(txd == 1'b1, "R1", "reset txd idle", txd, 1);
      chk(buf_empty == 1'b1, "R2", "reset buf_empty", buf_empty, 1);
      chk(tx_irq == 1'b0, "R4", "reset tx_irq", tx_irq, 0);
      chk(coll_flag == 1'b0, "R6", "reset coll_flag", coll_flag, 0);
      chk(txen == 1'b0, "R11", "reset txen", txen, 0);

      // R1 R4: back-to-back frames, handoff interrupt
      set_cfg(1, 0, 0, 0, 0);
      base = irq_cnt;
      put(8'hA5); put(8'h00); put(8'hFF); put(8'h3C);
      drain();
      chk(irq_cnt - base == 4, "R4", "handoff irq count", irq_cnt - base, 4);
      chk(coll_flag == 1'b0, "R6", "clean loopback no collision", coll_flag, 0);

      // R2: write while full is dropped
      put(8'h11); put(8'h22);
      raw_write(8'h33);
      chk(buf_empty == 1'b0, "R2", "buffer still holds queued byte", buf_empty, 0);
      drain();
      tick(50);
      chk(sb_q.size() == 0, "R2", "scoreboard empty", sb_q.size(), 0);

      // R5: frame-complete interrupt
      set_cfg(1, 1, 0, 0, 0);
      base = irq_cnt;
      put(8'h5A); put(8'h81);
      drain();
      tick(4);
      chk(irq_cnt - base == 2, "R5", "frame-done irq count", irq_cnt - base, 2);

      // R11: disabled transmitter holds the byte
      set_cfg(0, 0, 0, 0, 0);
      put(8'h77);
      count_low(60, lows);
      chk(lows == 0, "R11", "txd low cycles while disabled", lows, 0);
      chk(buf_empty == 1'b0, "R11", "byte held while disabled", buf_empty, 0);
      set_cfg(1, 0, 0, 0, 0);
      drain();

      // R10: start synchronization to an rxd falling edge
      loop_en = 0; rxd_drv = 1;
      tick(2);
      set_cfg(1, 0, 0, 0, 1);
      chk(sync_pend == 1'b1, "R10", "sync armed", sync_pend, 1);
      put(8'hC3);
      count_low(40, lows);
      chk(lows == 0, "R10", "no start before rxd edge", lows, 0);
      chk(sync_pend == 1'b1, "R10", "sync still armed", sync_pend, 1);
      @(negedge clk); rxd_drv = 0;
      tick(3);
      chk(sync_pend == 1'b0, "R10", "sync cleared at start", sync_pend, 0);
      chk(txd == 1'b0, "R10", "start bit after rxd edge", txd, 0);
      drain();
      chk(coll_flag == 1'b1, "R6", "mismatch sets flag", coll_flag, 1);
      rxd_drv = 1; loop_en = 1;
      tick(2);
      pulse_clr();
      chk(coll_flag == 1'b0, "R8", "flag cleared", coll_flag, 0);

      // R7: timer strobe as sampling source
      set_cfg(1, 0, 1, 0, 0);
      loop_inv = 1;
      put(8'h96);
      drain();
      chk(coll_flag == 1'b0, "R7", "no strobe no collision", coll_flag, 0);
      put(8'h69);
      @(negedge clk);
      while (txd) @(negedge clk);
      tick(5);
      @(negedge clk); tmr_uf = 1;
      @(negedge clk); tmr_uf = 0;
      chk(coll_flag == 1'b1, "R7", "timer strobe collision", coll_flag, 1);
      drain();
      loop_inv = 0;
      pulse_clr();
      chk(coll_flag == 1'b0, "R8", "flag cleared after timer test", coll_flag, 0);

      // R9: collision auto-clears enable and aborts at bit boundary
      mon_en = 0;
      set_cfg(1, 0, 0, 1, 0);
      loop_inv = 1;
      fork
         count_low(60, lows);
         begin
            raw_write(8'hE1);
            while (!buf_empty) @(negedge clk);
            raw_write(8'h1E);
         end
      join
      chk(lows == BD, "R9", "low cycles before abort", lows, BD);
      chk(coll_flag == 1'b1, "R9", "collision flagged", coll_flag, 1);
      chk(txen == 1'b0, "R9", "enable auto-cleared", txen, 0);
      chk(buf_empty == 1'b1, "R9", "buffer flushed", buf_empty, 1);
      loop_inv = 0;
      set_cfg(1, 0, 0, 0, 0);
      count_low(60, lows);
      chk(lows == 0, "R9", "flushed byte never sent", lows, 0);
      pulse_clr();
      mon_en = 1;

      report();
   end
endmodule